// File: doc/BRIEF.md
# Sixteenth-Second Real-Time Counter with Alarms

This block is a real-time clock peripheral on a simple 32-bit register bus. Reference clock edges arrive as single-cycle pulses that are synchronous to the bus clock. A programmable prescaler turns them into counting steps. With a 32.768 kHz reference and a divider value of 1023, the counter steps at 16 Hz. The 32-bit counter therefore holds time in sixteenths of a second: the lowest four bits are the fraction and the upper bits are whole seconds. Software can load the counter at any time. Once it reaches its maximum value it rolls over to zero and keeps running.

Two alarm compare registers are checked against the counter whenever it steps. A status register gathers three sticky events: alarm 0, alarm 1 and a once-per-second event. Each event has its own enable bit in the same register. A single interrupt line is raised while any event is pending together with its enable. A second-boundary pulse output marks each whole-second rollover of the fraction bits.

Several other registers complete the map. A clock-select register gates counting, and the counter runs only while it holds 3. A retained 32-bit scratch register lets software extend the count beyond 32 bits. A spare control register is plain storage.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset every register reads 0, irq is 0 and the counter does not advance on reference pulses.
- R2: The registers below are plain 32-bit read/write storage at these byte offsets: alarm 0 at 0x04, alarm 1 at 0x18, spare control at 0x14 and retained scratch at 0x40. Any unmapped offset reads 0. Writing the scratch or spare control register has no effect on counting.
- R3: The counter advances only while the clock-select register (0x1C) holds 3. Any other value is stored, reads back as written, and stops counting.
- R4: With divider value D written at 0x0C, the counter (0x00) increments once every 2*(D+1) reference pulses.
- R5: A write to the counter appears on the next clock and restarts the prescaler, so the next increment comes a full 2*(D+1) pulses later. The counter wraps from 0xFFFFFFFF to 0 and keeps running.
- R6: The status register is at 0x08. The enable bits are read/write: bit 2 enables alarm 0, bit 3 enables the second event and bit 6 enables alarm 1. Bit 5 and bits 31:7 always read 0.
- R7: Alarm 0 sets event bit 0 and alarm 1 sets event bit 4. An event sets when an increment brings the counter to that alarm's value while the matching enable is 1. No event is set while the enable is 0.
- R8: Status bit 1 sets when an increment leaves counter bits 3:0 at 0. This happens whatever the state of its enable bit.
- R9: Writing 1 to an event bit (0, 1 or 4) clears it, and writing 0 leaves it unchanged. If an event is set in the same cycle that it is cleared, the event stays set.
- R10: irq is the OR of (bit0 AND bit2), (bit1 AND bit3) and (bit4 AND bit6).
- R11: sec_tick is a one-cycle pulse. It is high in exactly the cycle in which the counter first shows a value whose bits 3:0 are 0 after an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle pulse per reference clock edge |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |
| sec_tick | output | 1 | Whole-second boundary pulse |

## Verification
The hardest case to produce is an alarm match that lands in the same bus cycle as a write-one-to-clear of that alarm's event. To create it, the bench first sets the event. It then reloads the counter to one below the alarm value, which also resets the prescaler to a known phase. With the divider at 0, a single reference pulse leaves the prescaler one pulse away from stepping. The next reference pulse and the status write are driven on the same falling edge. The bench then checks that the event is still set, and that a later clear on its own removes it. The prescaler restart is checked by loading the counter when the prescaler is one pulse short of a step, which shows that the step is pushed back by a full period.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFF_COUNT   = 'h00;
  localparam int unsigned OFF_ALARM0  = 'h04;
  localparam int unsigned OFF_STATUS  = 'h08;
  localparam int unsigned OFF_DIVIDE  = 'h0C;
  localparam int unsigned OFF_SPARE   = 'h14;
  localparam int unsigned OFF_ALARM1  = 'h18;
  localparam int unsigned OFF_CLKSEL  = 'h1C;
  localparam int unsigned OFF_KEEP    = 'h40;

  localparam int unsigned BIT_A0_EVT = 0;
  localparam int unsigned BIT_TK_EVT = 1;
  localparam int unsigned BIT_A0_EN  = 2;
  localparam int unsigned BIT_TK_EN  = 3;
  localparam int unsigned BIT_A1_EVT = 4;
  localparam int unsigned BIT_A1_EN  = 6;

  localparam logic [1:0] CLKSEL_RUN = 2'd3;

  // Sticky event update: a set in the same cycle beats a clear.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

  // Index of the last prescaler state before a step: 2*(div+1)-1.
  function automatic logic [32:0] presc_last(input logic [31:0] div);
    return {div, 1'b1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_pulse,
  input  logic [DIV_W-1:0] div,
  output logic             step
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] last;
  logic          at_end;
  logic [32:0]   last_wide;

  assign last_wide = rtc_pkg::presc_last(32'(div));
  assign last      = last_wide[PW-1:0];
  assign at_end    = (phase_q >= last);
  assign step      = run & ref_pulse & at_end & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run && ref_pulse) begin
      phase_q <= at_end ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_inc,
  output logic             advance,
  output logic             wrap,
  output logic             sec_pulse
);
  logic [CNT_W-1:0] cnt_q;
  logic             sec_q;

  assign cnt       = cnt_q;
  assign cnt_inc   = cnt_q + 1'b1;
  assign advance   = step & ~load;
  assign wrap      = advance & (cnt_inc[SUB_W-1:0] == '0);
  assign sec_pulse = sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sec_q <= 1'b0;
    end else begin
      sec_q <= wrap;
      if (load)         cnt_q <= load_val;
      else if (advance) cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int CNT_W = 32,
  parameter int N_ALM = 2
) (
  input  logic                   advance,
  input  logic [CNT_W-1:0]       cnt_inc,
  input  logic [N_ALM*CNT_W-1:0] alarms,
  output logic [N_ALM-1:0]       hit
);
  for (genvar i = 0; i < N_ALM; i++) begin : g_cmp
    assign hit[i] = advance & (cnt_inc == alarms[i*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       a0_hit,
  input  logic       a1_hit,
  input  logic       tk_hit,
  output logic [7:0] status,
  output logic       a0_set,
  output logic       irq
);
  import rtc_pkg::*;

  logic a0_evt_q, a1_evt_q, tk_evt_q;
  logic a0_en_q, a1_en_q, tk_en_q;
  logic a1_set;

  assign a0_set = a0_hit & a0_en_q;
  assign a1_set = a1_hit & a1_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a0_evt_q <= 1'b0; a1_evt_q <= 1'b0; tk_evt_q <= 1'b0;
      a0_en_q  <= 1'b0; a1_en_q  <= 1'b0; tk_en_q  <= 1'b0;
    end else begin
      a0_evt_q <= sticky_next(a0_evt_q, wr & wdata[BIT_A0_EVT], a0_set);
      a1_evt_q <= sticky_next(a1_evt_q, wr & wdata[BIT_A1_EVT], a1_set);
      tk_evt_q <= sticky_next(tk_evt_q, wr & wdata[BIT_TK_EVT], tk_hit);
      if (wr) begin
        a0_en_q <= wdata[BIT_A0_EN];
        a1_en_q <= wdata[BIT_A1_EN];
        tk_en_q <= wdata[BIT_TK_EN];
      end
    end
  end

  always_comb begin
    status             = '0;
    status[BIT_A0_EVT] = a0_evt_q;
    status[BIT_TK_EVT] = tk_evt_q;
    status[BIT_A0_EN]  = a0_en_q;
    status[BIT_TK_EN]  = tk_en_q;
    status[BIT_A1_EVT] = a1_evt_q;
    status[BIT_A1_EN]  = a1_en_q;
  end

  assign irq = (a0_evt_q & a0_en_q) | (tk_evt_q & tk_en_q) | (a1_evt_q & a1_en_q);
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sec_tick
);
  import rtc_pkg::*;

  localparam int N_ALM = 2;
  localparam int SEL_W = DATA_W;

  logic              wr_any;
  logic              wr_cnt, wr_a0, wr_a1, wr_st, wr_div, wr_spare, wr_sel, wr_keep;
  logic [DATA_W-1:0] alarm0_q, alarm1_q, spare_q, keep_q;
  logic [DIV_W-1:0]  div_q;
  logic [SEL_W-1:0]  clksel_q;
  logic              run;
  logic              step;
  logic [DATA_W-1:0] cnt, cnt_inc;
  logic              advance, wrap;
  logic [N_ALM-1:0]  hit;
  logic [7:0]        status;
  logic              a0_set;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  assign wr_any   = bus_sel & bus_wr;
  assign wr_cnt   = wr_any & at(bus_addr, OFF_COUNT);
  assign wr_a0    = wr_any & at(bus_addr, OFF_ALARM0);
  assign wr_a1    = wr_any & at(bus_addr, OFF_ALARM1);
  assign wr_st    = wr_any & at(bus_addr, OFF_STATUS);
  assign wr_div   = wr_any & at(bus_addr, OFF_DIVIDE);
  assign wr_spare = wr_any & at(bus_addr, OFF_SPARE);
  assign wr_sel   = wr_any & at(bus_addr, OFF_CLKSEL);
  assign wr_keep  = wr_any & at(bus_addr, OFF_KEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm0_q <= '0; alarm1_q <= '0; spare_q <= '0; keep_q <= '0;
      div_q    <= '0; clksel_q <= '0;
    end else begin
      if (wr_a0)    alarm0_q <= bus_wdata;
      if (wr_a1)    alarm1_q <= bus_wdata;
      if (wr_spare) spare_q  <= bus_wdata;
      if (wr_keep)  keep_q   <= bus_wdata;
      if (wr_div)   div_q    <= bus_wdata[DIV_W-1:0];
      if (wr_sel)   clksel_q <= bus_wdata;
    end
  end

  assign run = (clksel_q == SEL_W'(CLKSEL_RUN));

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(wr_cnt),
    .ref_pulse(ref_pulse), .div(div_q), .step(step)
  );

  rtc_counter #(.CNT_W(DATA_W), .SUB_W(SUB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(bus_wdata), .step(step),
    .cnt(cnt), .cnt_inc(cnt_inc), .advance(advance), .wrap(wrap), .sec_pulse(sec_tick)
  );

  rtc_alarm_match #(.CNT_W(DATA_W), .N_ALM(N_ALM)) u_match (
    .advance(advance), .cnt_inc(cnt_inc), .alarms({alarm1_q, alarm0_q}), .hit(hit)
  );

  rtc_status u_status (
    .clk(clk), .rst_n(rst_n), .wr(wr_st), .wdata(bus_wdata[7:0]),
    .a0_hit(hit[0]), .a1_hit(hit[1]), .tk_hit(wrap),
    .status(status), .a0_set(a0_set), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if      (at(bus_addr, OFF_COUNT))  bus_rdata = cnt;
    else if (at(bus_addr, OFF_ALARM0)) bus_rdata = alarm0_q;
    else if (at(bus_addr, OFF_STATUS)) bus_rdata = DATA_W'(status);
    else if (at(bus_addr, OFF_DIVIDE)) bus_rdata = DATA_W'(div_q);
    else if (at(bus_addr, OFF_SPARE))  bus_rdata = spare_q;
    else if (at(bus_addr, OFF_ALARM1)) bus_rdata = alarm1_q;
    else if (at(bus_addr, OFF_CLKSEL)) bus_rdata = clksel_q;
    else if (at(bus_addr, OFF_KEEP))   bus_rdata = keep_q;
  end
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk #(
  parameter int DATA_W = 32,
  parameter int SUB_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              step,
  input logic              load,
  input logic [DATA_W-1:0] cnt,
  input logic              wrap,
  input logic              sec_tick,
  input logic [7:0]        status,
  input logic              st_wr,
  input logic              st_clr0,
  input logic              a0_set,
  input logic              irq
);
  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step) && !$past(load)) |-> $stable(cnt));
  // R3
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> run);
  // R8
  tick_evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(wrap));
  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_wr && st_clr0) && !$past(a0_set)) |-> !status[0]);
  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && !status[3] && !status[6]) |-> !irq);
  // R11
  sec_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (cnt[SUB_W-1:0] == '0));
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .step(step), .load(wr_cnt), .cnt(cnt),
  .wrap(wrap), .sec_tick(sec_tick), .status(status), .st_wr(wr_st),
  .st_clr0(bus_wdata[0]), .a0_set(a0_set), .irq(irq)
);

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_pulse = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sec_tick;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rtc_alarm_timer u_rtc_alarm_timer (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sec_tick(sec_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
    end
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic test_reset;
    expect_reg("R1 count", 8'h00, 0);
    expect_reg("R1 status", 8'h08, 0);
    expect_reg("R1 clksel", 8'h1C, 0);
    expect_reg("R1 keep", 8'h40, 0);
    chk("R1 irq", 32'(irq), 0);
    pulses(4);
    expect_reg("R1 count idle", 8'h00, 0);
  endtask

  task automatic test_regs;
    wr(8'h04, 32'hA5A5_0001); wr(8'h18, 32'h5A5A_0002);
    wr(8'h14, 32'h0000_1234); wr(8'h40, 32'hCAFE_F00D);
    expect_reg("R2 alarm0", 8'h04, 32'hA5A5_0001);
    expect_reg("R2 alarm1", 8'h18, 32'h5A5A_0002);
    expect_reg("R2 spare", 8'h14, 32'h0000_1234);
    expect_reg("R2 keep", 8'h40, 32'hCAFE_F00D);
    expect_reg("R2 unmapped", 8'h3C, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    expect_reg("R6 status enables", 8'h08, 32'h0000_004C);
    wr(8'h08, 0);
    expect_reg("R6 status off", 8'h08, 0);
  endtask

  task automatic test_clksel;
    wr(8'h00, 32'h5);
    pulses(4);
    expect_reg("R3 stopped sel0", 8'h00, 32'h5);
    wr(8'h1C, 3);
    expect_reg("R3 sel readback", 8'h1C, 3);
    wr(8'h00, 32'h5);
    pulses(4);
    expect_reg("R3 running", 8'h00, 32'h7);
    wr(8'h1C, 5);
    expect_reg("R3 reserved readback", 8'h1C, 5);
    pulses(4);
    expect_reg("R3 stopped sel5", 8'h00, 32'h7);
    wr(8'h1C, 3);
  endtask

  task automatic test_rate;
    wr(8'h0C, 2);
    expect_reg("R4 div readback", 8'h0C, 2);
    wr(8'h00, 32'h100);
    pulses(5);
    expect_reg("R4 before period", 8'h00, 32'h100);
    pulses(1);
    expect_reg("R4 one period", 8'h00, 32'h101);
    pulses(6);
    expect_reg("R4 two periods", 8'h00, 32'h102);
    wr(8'h0C, 0);
  endtask

  task automatic test_wrap;
    wr(8'h08, 32'h13);
    wr(8'h00, 32'hFFFF_FFFF);
    pulses(2);
    expect_reg("R5 wrap", 8'h00, 0);
    chk("R11 sec_tick high", 32'(sec_tick), 1);
    expect_reg("R8 tick event no enable", 8'h08, 32'h02);
    chk("R10 irq masked", 32'(irq), 0);
    @(negedge clk);
    chk("R11 sec_tick one cycle", 32'(sec_tick), 0);
    wr(8'h08, 32'h08);
    chk("R10 irq tick", 32'(irq), 1);
    wr(8'h08, 32'h0A);
    expect_reg("R9 tick clear", 8'h08, 32'h08);
    chk("R10 irq after clear", 32'(irq), 0);
    wr(8'h08, 0);
  endtask

  task automatic test_restart;
    wr(8'h0C, 1);
    wr(8'h00, 32'h30);
    pulses(3);
    wr(8'h00, 32'h40);
    pulses(3);
    expect_reg("R5 restart holds", 8'h00, 32'h40);
    pulses(1);
    expect_reg("R5 restart full period", 8'h00, 32'h41);
    wr(8'h0C, 0);
  endtask

  task automatic test_alarm0;
    wr(8'h08, 32'h13); wr(8'h08, 32'h04);
    wr(8'h04, 32'h25); wr(8'h00, 32'h23);
    pulses(2);
    expect_reg("R7 alarm0 before", 8'h08, 32'h04);
    pulses(2);
    expect_reg("R7 alarm0 set", 8'h08, 32'h05);
    chk("R10 irq alarm0", 32'(irq), 1);
    wr(8'h08, 32'h04);
    expect_reg("R9 write zero keeps", 8'h08, 32'h05);
    wr(8'h08, 32'h05);
    expect_reg("R9 write one clears", 8'h08, 32'h04);
    chk("R10 irq cleared", 32'(irq), 0);
    wr(8'h08, 0);
    wr(8'h00, 32'h23);
    pulses(4);
    expect_reg("R7 disabled count", 8'h00, 32'h25);
    expect_reg("R7 disabled no event", 8'h08, 0);
  endtask

  task automatic test_alarm1;
    wr(8'h08, 32'h53);
    wr(8'h08, 32'h40);
    wr(8'h18, 32'h3D); wr(8'h00, 32'h3B);
    pulses(4);
    expect_reg("R7 alarm1 set", 8'h08, 32'h50);
    chk("R10 irq alarm1", 32'(irq), 1);
    wr(8'h08, 32'h50);
    expect_reg("R9 alarm1 clear", 8'h08, 32'h40);
    chk("R10 irq alarm1 clear", 32'(irq), 0);
    wr(8'h08, 0);
  endtask

  task automatic test_collide;
    wr(8'h04, 32'h51); wr(8'h08, 32'h04);
    wr(8'h00, 32'h50);
    pulses(2);
    expect_reg("R7 collide setup", 8'h08, 32'h05);
    wr(8'h00, 32'h50);
    pulses(1);
    @(negedge clk);
    ref_pulse = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h05;
    @(negedge clk);
    ref_pulse = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    expect_reg("R9 set beats clear cnt", 8'h00, 32'h51);
    expect_reg("R9 set beats clear", 8'h08, 32'h05);
    wr(8'h08, 32'h05);
    expect_reg("R9 later clear", 8'h08, 32'h04);
    wr(8'h08, 0);
  endtask

  task automatic test_keep;
    wr(8'h00, 32'h70);
    pulses(1);
    wr(8'h40, 32'h0BAD_CAFE);
    wr(8'h14, 32'h77);
    pulses(1);
    expect_reg("R2 keep no effect on count", 8'h00, 32'h71);
    expect_reg("R2 keep value", 8'h40, 32'h0BAD_CAFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset;
    test_regs;
    test_clksel;
    test_rate;
    test_wrap;
    test_restart;
    test_alarm0;
    test_alarm1;
    test_collide;
    test_keep;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule